// File: doc/BRIEF.md
# Layer Priority Pixel Compositor

This block merges three layers of one screen pixel into a single color. A sprite pixel, a plane A pixel (or a window pixel in its place) and a plane B pixel arrive together on each accepted input beat, along with a window-active flag and a background color index. Each pixel code is 7 bits wide. Bit 6 is the priority bit, bits 5:4 select a palette and bits 3:0 give the color index. An index of 0 makes the pixel transparent.

The winner is chosen in two tiers. All opaque pixels with the priority bit set come first, ranked sprite, then plane A, then plane B. Below them come the remaining opaque pixels in the same layer order. When no layer is opaque, the background index is used. The winner's 6-bit code (palette and index) addresses a 64-entry color RAM. Software-side logic loads that RAM through a separate write port.

The result goes out one beat later with three parts: the color word, a priority flag and a 3-bit source tag. Both data sides use valid/ready. An output beat is held until it is taken. A new input beat is accepted only when the output register is empty or is being drained in the same cycle.

Top module: `layer_compositor`

## Requirements
- R1: Pixel code layout is priority in bit 6, palette in bits 5:4 and color index in bits 3:0. A pixel whose bits 3:0 are 0 is transparent and never wins, whatever its other bits hold.
- R2: Among opaque pixels with bit 6 set, the sprite beats plane A and plane A beats plane B.
- R3: Any opaque pixel with bit 6 set beats every opaque pixel with bit 6 clear. Among pixels with bit 6 clear, the order is again sprite, then plane A, then plane B.
- R4: When all three layers are transparent, the lookup code is `bg_index`, the priority flag is 0 and the source tag is 0.
- R5: The output color equals the color RAM entry addressed by the winner's bits 5:0.
- R6: `out_prio` equals bit 6 of the winning pixel.
- R7: Source tags are 0 for background, 1 for plane A, 2 for plane B, 3 for sprite and 4 for window. A winning plane A pixel is tagged 4 when `win_active` is set on its beat.
- R8: After reset, `out_valid` is 0. A beat accepted at a clock edge is presented with `out_valid` high right after that edge. `out_valid` falls after a drain edge that accepts no new beat.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output fields stay unchanged.
- R10: A color RAM write to the entry being looked up on the same edge returns the old value. Later lookups see the new value.
- R11: Color RAM writes take effect whether or not the data path is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| spr_px | input | 7 | Sprite pixel code |
| pla_px | input | 7 | Plane A or window pixel code |
| plb_px | input | 7 | Plane B pixel code |
| win_active | input | 1 | Plane A slot carries a window pixel |
| bg_index | input | 6 | Background color RAM index |
| cram_we | input | 1 | Color RAM write enable |
| cram_waddr | input | 6 | Color RAM write address |
| cram_wdata | input | 9 | Color RAM write data |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat taken by sink |
| out_color | output | 9 | Resolved color word |
| out_prio | output | 1 | Priority bit of winning pixel |
| out_src | output | 3 | Source tag of winner |

## Verification
The assertions check several properties on every cycle. Output fields must hold while stalled, and an accepted beat must appear on the next cycle. Output valid must drop when nothing new is taken. The source tag must stay in its legal range. A background result must never carry the priority flag, and a window beat must never be tagged as plane A. Other behaviour can only be shown by bench scenarios against the reference model. This covers the full six-level ordering, the color values returned from the RAM, the old-value result on a same-entry write and lookup, and writes landing during a stall.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int PX_W     = 7;
  localparam int PRIO_BIT = 6;
  localparam int CODE_W   = 6;
  localparam int IDX_W    = 4;
  localparam int N_LAYER  = 3;

  typedef enum logic [2:0] {
    SRC_BG  = 3'd0,
    SRC_A   = 3'd1,
    SRC_B   = 3'd2,
    SRC_SPR = 3'd3,
    SRC_WIN = 3'd4
  } src_e;
endpackage

// File: rtl/layer_arbiter.sv
module layer_arbiter
  import comp_pkg::*;
(
  input  logic [PX_W-1:0]   spr,
  input  logic [PX_W-1:0]   pla,
  input  logic [PX_W-1:0]   plb,
  input  logic              win,
  input  logic [CODE_W-1:0] bg,
  output logic [CODE_W-1:0] code,
  output logic              prio,
  output src_e              src
);
  // rank order: 0 sprite, 1 plane A / window, 2 plane B
  logic [PX_W-1:0] px [N_LAYER];
  src_e            tag [N_LAYER];
  logic [N_LAYER-1:0] hi_hit, lo_hit;

  assign px[0]  = spr;
  assign px[1]  = pla;
  assign px[2]  = plb;
  assign tag[0] = SRC_SPR;
  assign tag[1] = win ? SRC_WIN : SRC_A;
  assign tag[2] = SRC_B;

  for (genvar g = 0; g < N_LAYER; g++) begin : g_hit
    assign lo_hit[g] = |px[g][IDX_W-1:0];
    assign hi_hit[g] = lo_hit[g] & px[g][PRIO_BIT];
  end

  always_comb begin
    code = bg;
    prio = 1'b0;
    src  = SRC_BG;
    // scan from lowest rank up so the best rank is written last
    for (int i = N_LAYER - 1; i >= 0; i--) begin
      if (lo_hit[i]) begin
        code = px[i][CODE_W-1:0];
        prio = px[i][PRIO_BIT];
        src  = tag[i];
      end
    end
    if (|hi_hit) begin
      for (int i = N_LAYER - 1; i >= 0; i--) begin
        if (hi_hit[i]) begin
          code = px[i][CODE_W-1:0];
          prio = 1'b1;
          src  = tag[i];
        end
      end
    end
  end
endmodule

// File: rtl/color_ram.sv
module color_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int COLOR_W = 9,
  parameter int ENTRIES = 64,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PX_W-1:0]    spr_px,
  input  logic [PX_W-1:0]    pla_px,
  input  logic [PX_W-1:0]    plb_px,
  input  logic               win_active,
  input  logic [AW-1:0]      bg_index,
  input  logic               cram_we,
  input  logic [AW-1:0]      cram_waddr,
  input  logic [COLOR_W-1:0] cram_wdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [COLOR_W-1:0] out_color,
  output logic               out_prio,
  output logic [2:0]         out_src
);
  logic [CODE_W-1:0] arb_code;
  logic              arb_prio;
  src_e              arb_src;
  logic              accept;

  layer_arbiter u_arb (
    .spr (spr_px),
    .pla (pla_px),
    .plb (plb_px),
    .win (win_active),
    .bg  (bg_index),
    .code(arb_code),
    .prio(arb_prio),
    .src (arb_src)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  color_ram #(.DEPTH(ENTRIES), .DW(COLOR_W)) u_cram (
    .clk  (clk),
    .we   (cram_we),
    .waddr(cram_waddr),
    .wdata(cram_wdata),
    .re   (accept),
    .raddr(arb_code[AW-1:0]),
    .rdata(out_color)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prio  <= 1'b0;
      out_src   <= SRC_BG;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_prio  <= arb_prio;
      out_src   <= arb_src;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_color) && $stable(out_prio) && $stable(out_src));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);

  assert_tag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_src <= 3'd4);

  assert_window_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> arb_src != SRC_A);

  assert_bg_noprio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src == 3'd0 |-> !out_prio);
endmodule

// File: tb/test_layer_compositor.sv
`timescale 1ns/1ps
module test_layer_compositor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       b_valid = 0, b_win = 0, b_we = 0, b_ordy = 1;
  logic [6:0] b_spr = 0, b_pla = 0, b_plb = 0;
  logic [5:0] b_bg = 0, b_waddr = 0;
  logic [8:0] b_wdata = 0;
  logic       in_ready, out_valid, out_prio;
  logic [8:0] out_color;
  logic [2:0] out_src;

  layer_compositor i_layer_compositor (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(in_ready),
    .spr_px(b_spr), .pla_px(b_pla), .plb_px(b_plb), .win_active(b_win),
    .bg_index(b_bg), .cram_we(b_we), .cram_waddr(b_waddr), .cram_wdata(b_wdata),
    .out_valid(out_valid), .out_ready(b_ordy), .out_color(out_color),
    .out_prio(out_prio), .out_src(out_src)
  );

  int checks = 0, failures = 0;
  logic [8:0] m_cram [64];
  logic       m_valid = 0, m_prio = 0;
  logic [8:0] m_color = 0;
  logic [2:0] m_src = 0;
  logic       rdy_pre;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic resolve(input logic [6:0] s, a, b, input logic w, input logic [5:0] bg,
                         output logic [5:0] code, output logic p, output logic [2:0] src);
    logic [6:0] lay [3];
    int tg [3];
    bit done;
    lay[0] = s; lay[1] = a; lay[2] = b;
    tg[0] = 3; tg[1] = w ? 4 : 1; tg[2] = 2;
    code = bg; p = 0; src = 0; done = 0;
    for (int tier = 1; tier >= 0; tier--)
      for (int k = 0; k < 3; k++)
        if (!done && lay[k][3:0] != 0 && (tier == 0 || lay[k][6])) begin
          done = 1; code = lay[k][5:0]; p = lay[k][6]; src = 3'(tg[k]);
        end
  endtask

  // one clock: check ready, advance model, compare outputs
  task automatic step();
    logic [5:0] c; logic p; logic [2:0] s;
    #1;
    rdy_pre = in_ready;
    if (rst_n) chk(in_ready == (!m_valid || b_ordy), "R9", in_ready, !m_valid || b_ordy);
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) m_valid = 0;
    else if (b_valid && rdy_pre) begin
      resolve(b_spr, b_pla, b_plb, b_win, b_bg, c, p, s);
      m_valid = 1; m_color = m_cram[c]; m_prio = p; m_src = s;
    end else if (b_ordy) m_valid = 0;
    if (b_we) m_cram[b_waddr] = b_wdata;
    chk(out_valid == m_valid, "R8", out_valid, m_valid);
    if (m_valid) begin
      chk(out_color == m_color, "R5", out_color, m_color);
      chk(out_prio == m_prio, "R6", out_prio, m_prio);
      chk(out_src == m_src, "R7", out_src, m_src);
    end
  endtask

  task automatic send(input logic [6:0] s, a, b, input logic w, input logic [5:0] bg);
    b_spr = s; b_pla = a; b_plb = b; b_win = w; b_bg = bg; b_valid = 1; b_ordy = 1;
    step();
    b_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] held;
    @(negedge clk);
    step(); step();
    chk(out_valid == 0, "R8 reset", out_valid, 0);
    rst_n = 1;
    // load the color RAM
    for (int i = 0; i < 64; i++) begin
      b_we = 1; b_waddr = 6'(i); b_wdata = 9'((i * 37) ^ 9'h155);
      step();
    end
    b_we = 0;

    // R2: high sprite beats high plane A and B
    send(7'h45, 7'h5A, 7'h47, 0, 6'd0);
    chk(out_src == 3 && out_color == m_cram[6'h05] && out_prio, "R2", out_src, 3);
    send(7'h00, 7'h6B, 7'h47, 0, 6'd0);
    chk(out_src == 1 && out_color == m_cram[6'h2B], "R2 A over B", out_src, 1);
    // R3: any high beats any low
    send(7'h05, 7'h1A, 7'h47, 0, 6'd0);
    chk(out_src == 2 && out_prio == 1 && out_color == m_cram[6'h07], "R3", out_src, 2);
    send(7'h05, 7'h1A, 7'h23, 0, 6'd0);
    chk(out_src == 3 && out_prio == 0, "R3 low tier", out_src, 3);
    // R1/R4: index 0 transparent despite palette/priority bits
    send(7'h30, 7'h70, 7'h60, 0, 6'h2E);
    chk(out_src == 0 && out_prio == 0 && out_color == m_cram[6'h2E], "R4", out_color, m_cram[6'h2E]);
    send(7'h70, 7'h00, 7'h19, 0, 6'h2E);
    chk(out_src == 2 && out_color == m_cram[6'h19], "R1", out_src, 2);
    // R7: window tag
    send(7'h00, 7'h13, 7'h44, 1, 6'd0);
    chk(out_src == 2, "R7 window low loses", out_src, 2);
    send(7'h00, 7'h53, 7'h44, 1, 6'd0);
    chk(out_src == 4, "R7 window tag", out_src, 4);
    // R10: same-edge write and read of one entry
    held = m_cram[6'h09];
    b_we = 1; b_waddr = 6'h09; b_wdata = ~held;
    send(7'h09, 7'h00, 7'h00, 0, 6'd0);
    b_we = 0;
    chk(out_color == held, "R10 old value", out_color, held);
    send(7'h09, 7'h00, 7'h00, 0, 6'd0);
    chk(out_color == 9'(~held), "R10 new value", out_color, 9'(~held));
    // R9/R11: stall, write during stall
    send(7'h4C, 7'h00, 7'h00, 0, 6'd0);
    held = out_color;
    b_ordy = 0; b_valid = 1; b_spr = 7'h01;
    b_we = 1; b_waddr = 6'h01; b_wdata = 9'h1A5;
    step();
    b_we = 0;
    for (int i = 0; i < 4; i++) step();
    chk(out_color == held && in_ready == 0, "R9 hold", out_color, held);
    b_ordy = 1;
    step();
    chk(out_color == 9'h1A5, "R11 stalled write", out_color, 9'h1A5);
    b_valid = 0; step();
    chk(out_valid == 0, "R8 drain", out_valid, 0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      b_valid = 1'($urandom_range(0, 3) != 0);
      b_ordy  = 1'($urandom_range(0, 2) != 0);
      b_spr = 7'($urandom); b_pla = 7'($urandom); b_plb = 7'($urandom);
      if ($urandom_range(0, 1) == 1) b_spr[3:0] = 0;
      if ($urandom_range(0, 1) == 1) b_pla[3:0] = 0;
      if ($urandom_range(0, 2) == 1) b_plb[3:0] = 0;
      b_win = 1'($urandom); b_bg = 6'($urandom);
      b_we = 1'($urandom_range(0, 3) == 0); b_waddr = 6'($urandom); b_wdata = 9'($urandom);
      step();
    end
    b_valid = 0; b_we = 0; b_ordy = 1;
    step();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule